// File: doc/BRIEF.md
# Strobe-Addressed One-Bit Memory Array

This block is a 64K-by-1 storage array. It is addressed over a narrow 8-bit bus that carries the address in two halves at different times. The row half comes first and is captured when the row strobe goes low. The column half follows on the same pins and is captured when the column strobe goes low. Both strobes are active low. There is no chip enable: the strobes alone decide when the bus is sampled. A single read/write select line and a single data bit in each direction complete the interface.

All inputs are sampled on the rising edge of the system clock. A strobe "falls" when it was high at the previous edge and is low at this one. The access starts at the column fall. With write selected, the data-in bit is stored at that edge. While the column strobe stays low, the addressed cell is shown on the data output. Several column falls under one row fall reuse the latched row. The data pins are plain levels with no handshake, so the block never applies back-pressure. Each strobe fall is one transaction, and the caller paces accesses by how it toggles the strobes.

Top module: `mxa_bitmem`

## Requirements
- R1: While reset is asserted, and after it is released with both strobes high, `dout` is 0. Reset does not clear stored cells.
- R2: At a clock edge where `row_stb_n` falls (sampled 1 at the previous edge, 0 at this edge), `addr` is latched as the row.
- R3: At a clock edge where `col_stb_n` falls with `wr_sel`=1, `din` is stored in cell {row, addr}. After that edge, `dout` shows the stored bit.
- R4: At a clock edge where `col_stb_n` falls with `wr_sel`=0, `addr` is latched as the column. After that edge, `dout` equals cell {row, column}.
- R5: After a clock edge at which `col_stb_n` is sampled high, `dout` is 0.
- R6: A column fall with no row fall at the same edge uses the most recently latched row.
- R7: While a strobe stays low, changes on `addr` are ignored. The latched row and column keep their values.
- R8: If both strobes fall at the same edge, `addr` serves as both row and column for that access.
- R9: Changes on `wr_sel` or `din` while `col_stb_n` stays low cause no write. A write happens only at a column fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Shared address bus, row half then column half |
| row_stb_n | input | 1 | Active-low row strobe |
| col_stb_n | input | 1 | Active-low column strobe |
| wr_sel | input | 1 | 1 = write at column fall, 0 = read |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 when the column strobe is high |

## Verification
A row register that latches at the wrong time, or misses a latch, does not show at once. It shows at the next column access as a bit read from the wrong row, which can be many cycles later. The checks therefore pair writes with later reads from other rows and other columns. A column register or write enable that follows `addr` or `wr_sel` while the strobe is held low corrupts a neighbouring cell. That damage appears only on a later read-back of that cell. A stale open-column flag shows one cycle after the column strobe rises, as a nonzero `dout`.

// File: rtl/mxa_pkg.sv
package mxa_pkg;
  localparam int unsigned MXA_AW = 8;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_e;
endpackage

// File: rtl/mxa_strobe_edge.sv
module mxa_strobe_edge #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stb_n,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_stb
    logic prev_n;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_n <= 1'b1;
      else        prev_n <= stb_n[i];
    end

    assign fall[i] = prev_n & ~stb_n[i];

    AST_SINGLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      fall[i] |=> !fall[i]); // R7
  end
endmodule

// File: rtl/mxa_addr_latch.sv
module mxa_addr_latch #(
  parameter int unsigned AW = mxa_pkg::MXA_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          row_fall,
  input  logic          col_fall,
  output logic [AW-1:0] row_q,
  output logic [AW-1:0] col_q,
  output logic [AW-1:0] row_eff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (row_fall) row_q <= addr;
      if (col_fall) col_q <= addr;
    end
  end

  // a row fall at the same edge as the column fall supplies the row itself
  assign row_eff = row_fall ? addr : row_q;

  AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    row_fall |=> row_q == $past(addr)); // R2
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !row_fall |=> $stable(row_q)); // R7
  AST_PAGE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (col_fall && !row_fall) |=> $stable(row_q)); // R6
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !col_fall |=> $stable(col_q)); // R7
endmodule

// File: rtl/mxa_cell_array.sv
module mxa_cell_array #(
  parameter int unsigned AW = mxa_pkg::MXA_AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wr_row,
  input  logic [AW-1:0] wr_col,
  input  logic          wdata,
  input  logic [AW-1:0] rd_row,
  input  logic [AW-1:0] rd_col,
  output logic          rdata
);
  localparam int unsigned ROWS = 1 << AW;
  localparam int unsigned COLS = 1 << AW;

  logic [COLS-1:0] rows_mem [ROWS];
  logic [COLS-1:0] rd_line;

  always_ff @(posedge clk) begin
    if (we) rows_mem[wr_row][wr_col] <= wdata;
  end

  assign rd_line = rows_mem[rd_row];
  assign rdata   = rd_line[rd_col];
endmodule

// File: rtl/mxa_bitmem.sv
module mxa_bitmem #(
  parameter int unsigned AW = mxa_pkg::MXA_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          row_stb_n,
  input  logic          col_stb_n,
  input  logic          wr_sel,
  input  logic          din,
  output logic          dout
);
  import mxa_pkg::*;

  logic [1:0]    falls;
  logic          row_fall, col_fall;
  logic [AW-1:0] row_q, col_q, row_eff;
  logic          cell_bit;
  logic          col_open;
  logic          write_en;

  mxa_strobe_edge #(.N(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .stb_n ({col_stb_n, row_stb_n}),
    .fall  (falls)
  );
  assign row_fall = falls[0];
  assign col_fall = falls[1];

  mxa_addr_latch #(.AW(AW)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .row_fall (row_fall),
    .col_fall (col_fall),
    .row_q    (row_q),
    .col_q    (col_q),
    .row_eff  (row_eff)
  );

  assign write_en = col_fall && (acc_e'(wr_sel) == ACC_WRITE);

  mxa_cell_array #(.AW(AW)) u_cells (
    .clk    (clk),
    .we     (write_en),
    .wr_row (row_eff),
    .wr_col (addr),
    .wdata  (din),
    .rd_row (row_q),
    .rd_col (col_q),
    .rdata  (cell_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         col_open <= 1'b0;
    else if (col_fall)  col_open <= 1'b1;
    else if (col_stb_n) col_open <= 1'b0;
  end

  assign dout = col_open & cell_bit;

  AST_WRITE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (col_fall && wr_sel) |=> dout == $past(din)); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    col_stb_n |=> dout == 1'b0); // R5
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> dout == 1'b0); // R1
endmodule

// File: tb/mxa_bitmem_tb.sv
`timescale 1ns/1ps
module mxa_bitmem_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic       row_stb_n = 1'b1;
  logic       col_stb_n = 1'b1;
  logic       wr_sel = 1'b0;
  logic       din = 1'b0;
  logic       dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mxa_bitmem u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .row_stb_n(row_stb_n),
    .col_stb_n(col_stb_n), .wr_sel(wr_sel), .din(din), .dout(dout)
  );

  // vector: {row_n, col_n, wr, din, addr[7:0], 3'b0, expected dout}
  function automatic logic [15:0] v(logic rn, logic cn, logic wr, logic d,
                                    logic [7:0] a, logic e);
    return {rn, cn, wr, d, a, 3'b000, e};
  endfunction

  localparam int NV = 26;
  localparam logic [15:0] VEC [NV] = '{
    v(1,1,0,0,8'h00,0),  // R1 idle after reset
    v(0,1,0,0,8'h12,0),  // R2 row fall 12, R5 dout 0
    v(0,0,1,1,8'h34,1),  // R3 write 1 at {12,34}
    v(0,0,1,0,8'h35,1),  // R7 R9 held low: no write, no relatch
    v(0,1,0,0,8'h00,0),  // R5 column released
    v(0,0,0,0,8'h34,1),  // R4 read {12,34}
    v(0,1,0,0,8'h00,0),  // R5
    v(0,0,1,1,8'h56,1),  // R6 page write {12,56}
    v(0,1,0,0,8'h00,0),  // R5
    v(0,0,1,0,8'h35,0),  // R6 page write 0 at {12,35}
    v(0,1,0,0,8'h00,0),  // R5
    v(1,1,0,0,8'h00,0),  // release row
    v(0,1,0,0,8'h13,0),  // R2 row 13
    v(0,0,1,0,8'h56,0),  // R3 write 0 at {13,56}
    v(0,1,0,0,8'h00,0),  // R5
    v(1,1,0,0,8'h00,0),
    v(0,1,0,0,8'h12,0),  // R2 row 12 again
    v(0,0,0,0,8'h56,1),  // R2 R4 {12,56} kept its 1
    v(0,1,0,0,8'h00,0),
    v(0,0,0,0,8'h35,0),  // R9 {12,35} holds 0
    v(1,1,0,0,8'h00,0),
    v(0,0,1,1,8'h77,1),  // R8 both fall: write {77,77}
    v(1,1,0,0,8'h00,0),  // R5
    v(0,1,0,0,8'h13,0),  // row 13
    v(0,0,1,1,8'h77,1),  // R8 setup: write 1 at {13,77}
    v(1,1,0,0,8'h00,0)
  };

  task automatic check(string req, logic exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s dout=%0b expected=%0b", req, dout, exp);
    end
  endtask

  task automatic drive(logic [15:0] w);
    row_stb_n = w[15]; col_stb_n = w[14]; wr_sel = w[13];
    din = w[12]; addr = w[11:4];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0s vec%0d", "-", i), VEC[i][0]);
    end

    // R8 read back {77,77} through a normal row/column pair
    @(negedge clk); drive(v(0,1,0,0,8'h77,0));
    @(negedge clk); drive(v(0,0,0,0,8'h77,0));
    @(negedge clk); check("R8", 1'b1);
    @(negedge clk); drive(v(1,1,0,0,8'h00,0));
    @(negedge clk); check("R5", 1'b0);

    // R4 open a read then reset mid-access: R1 output forced low
    @(negedge clk); drive(v(0,1,0,0,8'h12,0));
    @(negedge clk); drive(v(0,0,0,0,8'h34,0));
    @(negedge clk); check("R4", 1'b1);
    rst_n = 1'b0;
    @(negedge clk); check("R1", 1'b0);
    drive(v(1,1,0,0,8'h00,0));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R1", 1'b0);

    // R1 cells survive reset: {12,34} still 1
    @(negedge clk); drive(v(0,1,0,0,8'h12,0));
    @(negedge clk); drive(v(0,0,0,0,8'h34,0));
    @(negedge clk); check("R1", 1'b1);
    @(negedge clk); drive(v(1,1,0,0,8'h00,0));
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule